// File: doc/BRIEF.md
# Single-Wire Bus Slave Slot Decoder

This block is the device-side physical layer for one open-drain data line that a bus master drives low to mark resets and bit slots. The raw line passes through a two-flop synchronizer, and all edge detection uses the synchronized value. When a low lasts long enough, the block reports a reset. After the line rises again, it waits a short high time and then pulls the line low for a fixed time as a presence answer.

Every other falling edge starts a bit slot. For a write slot, the line is sampled a fixed time after the falling edge. The sampled bit is handed to the user side once the slot ends, so a low that grows into a reset never yields a stray bit. For a read slot, the user marks the slot as a read and supplies the bit before the falling edge. The block then either holds the line low for a fixed time (bit 0) or leaves it alone (bit 1). Byte assembly and command handling sit above this block.

Top module: `swire_slot_phy`

## Requirements
- R1: While and after synchronous reset, `line_pd_en`, `rst_seen` and `rx_valid` are all low until the line acts.
- R2: In a write slot (`rd_slot` low at the falling edge), the line is sampled 30 µs after the falling edge; high gives bit 1 and low gives bit 0. The bit is delivered on `rx_bit` with a one-cycle `rx_valid` pulse when the line is high again.
- R3: A continuous low of 400 µs or more produces exactly one one-cycle `rst_seen` pulse, no matter how long the low lasts.
- R4: A low shorter than 400 µs produces no `rst_seen` pulse.
- R5: After a reset low ends, the block waits 30 µs from the rising edge and then asserts `line_pd_en` for 120 µs.
- R6: A low that reaches reset length aborts the slot it started, so that slot produces no `rx_valid`.
- R7: In a read slot with transmit bit 0, `line_pd_en` holds the line low from just after the falling edge until 45 µs after it. With transmit bit 1, `line_pd_en` stays low for the whole slot.
- R8: `rd_slot` and `tx_bit` are captured at the falling edge; later changes during the slot have no effect. A read slot never produces `rx_valid`.
- R9: `line_pd_en` is never asserted for more than 120 µs in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw level of the shared data line |
| rd_slot | input | 1 | High if the next slot is a read slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| line_pd_en | output | 1 | Enable for the open-drain pull-down on the line |
| rst_seen | output | 1 | One-cycle pulse when a reset-length low is detected |
| rx_valid | output | 1 | One-cycle pulse when a received write bit is ready |
| rx_bit | output | 1 | Received write bit, valid with `rx_valid` |

## Verification
The bench targets a low of 390 µs that stays just under the reset limit. A decoder with a loose reset threshold would report a reset there, or drop the 0 bit that the slot carries. It also starts a write slot and then stretches it into a reset. A design that reported bits at the sample point instead of at slot end would leak a spurious 0 bit there.

Read slots check the line level at 15, 40 and 50 µs. A wrong hold length or a drive for a 1 shows up as a level error. Changing `tx_bit` in the middle of a slot exposes a decoder that does not capture the bit at the falling edge. The presence answer is sampled on both sides of its 30 µs and 150 µs boundaries.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSLOT,
        ST_WDONE,
        ST_RSLOT,
        ST_SLOT_END,
        ST_RST_LOW,
        ST_PRES_WAIT,
        ST_PRES_DRIVE
    } slot_state_e;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } line_ev_t;

    function automatic int unsigned us_ticks(input int unsigned us, input int unsigned tpu);
        return us * tpu;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/swire_sync_edge.sv
module swire_sync_edge
    import swire_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_in,
    output line_ev_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        ev.level = chain[STAGES-1];
        ev.fall  = prev & ~chain[STAGES-1];
        ev.rise  = ~prev & chain[STAGES-1];
    end
endmodule

// File: rtl/swire_low_timer.sv
module swire_low_timer #(
    parameter int unsigned RST_TICKS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic long_low
);
    localparam int unsigned W = $clog2(RST_TICKS + 1);

    logic [W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || level) begin
            low_cnt <= '0;
        end else if (low_cnt != W'(RST_TICKS)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign long_low = ~level && (low_cnt == W'(RST_TICKS - 1));
endmodule

// File: rtl/swire_slot_fsm.sv
module swire_slot_fsm
    import swire_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 50,
    parameter int unsigned PDH_US       = 30,
    parameter int unsigned PDL_US       = 120,
    parameter int unsigned WSAMP_US     = 30,
    parameter int unsigned RHOLD_US     = 45
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    input  logic     long_low,
    input  logic     rd_slot,
    input  logic     tx_bit,
    output logic     pd_en,
    output logic     rx_valid,
    output logic     rx_bit
);
    localparam int unsigned PDH_T = us_ticks(PDH_US, TICKS_PER_US);
    localparam int unsigned PDL_T = us_ticks(PDL_US, TICKS_PER_US);
    localparam int unsigned WS_T  = us_ticks(WSAMP_US, TICKS_PER_US);
    localparam int unsigned RH_T  = us_ticks(RHOLD_US, TICKS_PER_US);
    localparam int unsigned MAX_T = max4(PDH_T, PDL_T, WS_T, RH_T);
    localparam int unsigned CW    = $clog2(MAX_T + 1);

    slot_state_e   state;
    logic [CW-1:0] tcnt;
    logic          wbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            pd_en    <= 1'b0;
            rx_valid <= 1'b0;
            rx_bit   <= 1'b0;
            wbit     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tcnt     <= tcnt + 1'b1;
            if (long_low) begin
                state <= ST_RST_LOW;
                pd_en <= 1'b0;
                tcnt  <= '0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        tcnt <= '0;
                        if (ev.fall) begin
                            if (rd_slot) begin
                                state <= ST_RSLOT;
                                pd_en <= ~tx_bit;
                            end else begin
                                state <= ST_WSLOT;
                            end
                        end
                    end
                    ST_WSLOT: begin
                        if (tcnt == CW'(WS_T - 1)) begin
                            wbit  <= ev.level;
                            state <= ST_WDONE;
                        end
                    end
                    ST_WDONE: begin
                        tcnt <= '0;
                        if (ev.level) begin
                            rx_valid <= 1'b1;
                            rx_bit   <= wbit;
                            state    <= ST_IDLE;
                        end
                    end
                    ST_RSLOT: begin
                        if (tcnt == CW'(RH_T - 1)) begin
                            pd_en <= 1'b0;
                            state <= ST_SLOT_END;
                        end
                    end
                    ST_SLOT_END: begin
                        tcnt <= '0;
                        if (ev.level) state <= ST_IDLE;
                    end
                    ST_RST_LOW: begin
                        tcnt <= '0;
                        if (ev.rise) state <= ST_PRES_WAIT;
                    end
                    ST_PRES_WAIT: begin
                        if (tcnt == CW'(PDH_T - 1)) begin
                            pd_en <= 1'b1;
                            tcnt  <= '0;
                            state <= ST_PRES_DRIVE;
                        end
                    end
                    ST_PRES_DRIVE: begin
                        if (tcnt == CW'(PDL_T - 1)) begin
                            pd_en <= 1'b0;
                            state <= ST_SLOT_END;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/swire_slot_phy.sv
module swire_slot_phy
    import swire_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 50,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned RST_MIN_US   = 400,
    parameter int unsigned PDH_US       = 30,
    parameter int unsigned PDL_US       = 120,
    parameter int unsigned WSAMP_US     = 30,
    parameter int unsigned RHOLD_US     = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic rd_slot,
    input  logic tx_bit,
    output logic line_pd_en,
    output logic rst_seen,
    output logic rx_valid,
    output logic rx_bit
);
    localparam int unsigned RST_T = us_ticks(RST_MIN_US, TICKS_PER_US);

    line_ev_t ev;
    logic     long_low;

    swire_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .ev      (ev)
    );

    swire_low_timer #(.RST_TICKS(RST_T)) u_low (
        .clk      (clk),
        .rst      (rst),
        .level    (ev.level),
        .long_low (long_low)
    );

    swire_slot_fsm #(
        .TICKS_PER_US (TICKS_PER_US),
        .PDH_US       (PDH_US),
        .PDL_US       (PDL_US),
        .WSAMP_US     (WSAMP_US),
        .RHOLD_US     (RHOLD_US)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .long_low (long_low),
        .rd_slot  (rd_slot),
        .tx_bit   (tx_bit),
        .pd_en    (line_pd_en),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit)
    );

    assign rst_seen = long_low;
endmodule

// File: rtl/swire_slot_phy_chk.sv
module swire_slot_phy_chk #(
    parameter int unsigned TICKS_PER_US = 50,
    parameter int unsigned PDL_US       = 120
) (
    input logic clk,
    input logic rst,
    input logic line_pd_en,
    input logic rst_seen,
    input logic rx_valid
);
    localparam int unsigned PDL_T = PDL_US * TICKS_PER_US;

    int unsigned pd_run;

    always_ff @(posedge clk) begin
        if (rst || !line_pd_en) pd_run <= 0;
        else if (pd_run <= PDL_T) pd_run <= pd_run + 1;
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> (!line_pd_en && !rst_seen && !rx_valid));

    assert_rx_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_reset_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rst_seen |=> !rst_seen);

    assert_reset_kills_bit_R6: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> !rx_valid);

    assert_no_rx_while_driving_R8: assert property (@(posedge clk) disable iff (rst)
        line_pd_en |-> !rx_valid);

    assert_drive_length_R9: assert property (@(posedge clk) disable iff (rst)
        pd_run <= PDL_T);
endmodule

bind swire_slot_phy swire_slot_phy_chk #(
    .TICKS_PER_US (TICKS_PER_US),
    .PDL_US       (PDL_US)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_pd_en (line_pd_en),
    .rst_seen   (rst_seen),
    .rx_valid   (rx_valid)
);

// File: tb/swire_slot_phy_bench.sv
module swire_slot_phy_bench;
    localparam int TPU = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_low = 1'b0;
    logic rd_slot = 1'b0;
    logic tx_bit = 1'b1;
    logic line;
    logic line_pd_en, rst_seen, rx_valid, rx_bit;

    int checks = 0;
    int failures = 0;
    int rst_count = 0;
    int rx_total = 0;
    bit done = 1'b0;
    bit exp_q[$];

    always #10 clk = ~clk;

    assign line = ~(master_low | line_pd_en);

    swire_slot_phy #(.TICKS_PER_US(TPU)) u_swire_slot_phy (
        .clk        (clk),
        .rst        (rst),
        .line_in    (line),
        .rd_slot    (rd_slot),
        .tx_bit     (tx_bit),
        .line_pd_en (line_pd_en),
        .rst_seen   (rst_seen),
        .rx_valid   (rx_valid),
        .rx_bit     (rx_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_us(input int us);
        repeat (us * TPU) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each delivered write bit
    always @(negedge clk) begin
        if (!rst) begin
            if (rst_seen) rst_count++;
            if (rx_valid) begin
                rx_total++;
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected rx_valid", 1, 0);
                end else begin
                    chk("R2 rx_bit", int'(rx_bit), int'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic write_bit(input bit b);
        exp_q.push_back(b);
        master_low = 1'b1;
        wait_us(b ? 5 : 60);
        master_low = 1'b0;
        wait_us(b ? 75 : 20);
    endtask

    task automatic read_bit(input bit b, input bit flip_mid);
        int rx0;
        rx0 = rx_total;
        rd_slot = 1'b1;
        tx_bit = b;
        master_low = 1'b1;
        wait_us(2);
        master_low = 1'b0;
        if (flip_mid) tx_bit = ~b;
        wait_us(13);
        chk("R7 read level 15us", int'(line), int'(b));
        wait_us(25);
        chk("R7 read level 40us", int'(line), int'(b));
        wait_us(10);
        chk("R7 released by 50us", int'(line), 1);
        wait_us(25);
        rd_slot = 1'b0;
        tx_bit = 1'b1;
        wait_us(5);
        chk("R8 no rx_valid in read slot", rx_total, rx0);
    endtask

    task automatic reset_pulse(input int low_us);
        int r0;
        r0 = rst_count;
        master_low = 1'b1;
        wait_us(low_us);
        master_low = 1'b0;
        chk("R3 one rst_seen per reset", rst_count - r0, 1);
        wait_us(20);
        chk("R5 line high before presence", int'(line), 1);
        wait_us(20);
        chk("R5 presence low at 40us", int'(line), 0);
        wait_us(100);
        chk("R5 presence low at 140us", int'(line), 0);
        wait_us(20);
        chk("R5 presence released at 160us", int'(line), 1);
        wait_us(10);
    endtask

    initial begin
        int r0;
        int rx0;
        repeat (5) @(negedge clk);
        chk("R1 pd_en in reset", int'(line_pd_en), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 pd_en after reset", int'(line_pd_en), 0);
        chk("R1 rst_seen after reset", int'(rst_seen), 0);
        chk("R1 rx_valid after reset", int'(rx_valid), 0);

        reset_pulse(480);

        write_bit(1'b1);
        write_bit(1'b0);
        write_bit(1'b1);
        write_bit(1'b1);
        write_bit(1'b0);
        chk("R2 five bits delivered", rx_total, 5);

        read_bit(1'b0, 1'b0);
        read_bit(1'b1, 1'b0);
        read_bit(1'b0, 1'b1);
        read_bit(1'b1, 1'b1);

        // Just under the reset limit: a write 0 with no reset
        r0 = rst_count;
        rx0 = rx_total;
        exp_q.push_back(1'b0);
        master_low = 1'b1;
        wait_us(390);
        master_low = 1'b0;
        wait_us(20);
        chk("R4 no rst_seen for 390us low", rst_count, r0);
        chk("R2 bit after long write 0", rx_total - rx0, 1);
        wait_us(200);
        chk("R4 no presence after short low", int'(line), 1);

        // Write slot stretched into a reset
        rx0 = rx_total;
        reset_pulse(600);
        chk("R6 aborted slot gives no bit", rx_total, rx0);

        write_bit(1'b0);
        write_bit(1'b1);
        chk("R2 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule